// File: doc/BRIEF.md
# Management Serial Interface Master with PHY Discovery

This block drives the two-wire PHY management bus (a clock pin and a bidirectional data pin) as a bus master. It runs clause-22 style read and write frames on behalf of a host. It also runs a hardware discovery sweep that probes every PHY address for a device. The management clock comes from the system clock through a parameterized divider. The data pin is split into an output value, an output enable and an input, so that the pad tristate sits outside the block.

The host presents a one-cycle request with an operation code, a PHY address, a register number and write data. A request is taken only while `busy_o` is low. The block answers with a one-cycle `done_o` pulse, and with read data when the operation was a read.

During a discovery sweep the block reads both identifier registers at each address in ascending order. It stops at the first address whose identifiers pass the validity rules, then reports that address with a found flag. If no address passes, the flag stays low.

Top module: `mdio_scan_master`

## Requirements
- R1: Every frame opens with 32 cycles of the management clock with the data line driven to 1, followed by the start pattern 0 then 1.
- R2: Operation code `req_op_i` = 2'b00 is a read and 2'b01 is a write; 2'b10 and 2'b11 both start a discovery sweep. On the wire, a read puts the bits 1,0 after the start pattern and a write puts 0,1. Next come the 5-bit PHY address and then the 5-bit register number, both most significant bit first.
- R3: In a read frame, the master releases the data line (output enable low) for the two turnaround bits and the 16 data bits. It samples 16 bits most significant first and presents them on `rdata_o` in the cycle `done_o` pulses.
- R4: In a write frame, the master drives the turnaround as 1 then 0, then the 16 data bits most significant first, then one more clock with the output enable low. A write therefore has 65 clock pulses and a read has 64.
- R5: The data output changes only while the management clock is low. Input bits are taken at the end of the clock-high phase.
- R6: Outside a frame the management clock, the data output and the output enable are all low, both after reset and after every frame.
- R7: Within a frame, each high phase and each low phase of the management clock lasts exactly HALF_DIV system clock cycles.
- R8: A sweep reads register 2 and then register 3 at each PHY address, in the address order 0, 1, 2 and up to 31.
- R9: An address is valid only if both identifier words differ from 16'h0000, 16'hFFFF and 16'h8000. The sweep stops at the first valid address. At the `done_o` pulse it shows `found_o` = 1 and that address on `found_phy_o`.
- R10: If no address is valid, the sweep ends after address 31 with `found_o` = 0 and a `done_o` pulse.
- R11: A request that arrives while `busy_o` is high is ignored. It causes no frame, no register change at the PHY and no extra `done_o`.
- R12: `busy_o` rises the cycle after a request is accepted and falls in the cycle `done_o` is high. `done_o` is a single-cycle pulse, once per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, one cycle |
| req_op_i | input | 2 | 00 read, 01 write, 1x discovery sweep |
| req_phy_i | input | 5 | Target PHY address |
| req_reg_i | input | 5 | Target register number |
| req_wdata_i | input | DW | Write data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW | Data of the last host read |
| found_o | output | 1 | Last sweep found a valid PHY |
| found_phy_o | output | 5 | Address found by the last sweep |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The bench builds the block with HALF_DIV = 2, a 32-bit preamble, 16-bit data and identifier registers 2 and 3. With a divide of two, high and low phases are measurably longer than one system cycle, so a phase-width or sample-point fault shows up. A full 32-address sweep also stays near sixteen thousand cycles at this divide. That lets the bench run three complete sweeps: one that hits early, one that misses at every address, and one that hits only at address 31. A bus-level PHY model decodes each frame from the pins, answers reads from its own register array, and checks every bit and enable position against the frame layout.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SWEEP = 2'b10,
    OP_SWALT = 2'b11
  } mdio_op_e;

  localparam int unsigned ADDR_W = 5;
  localparam int unsigned REG_W  = 5;

  // identifier word acceptance rule for discovery
  function automatic logic id_word_ok(input logic [15:0] v);
    return (v != 16'h0000) && (v != 16'hFFFF) && (v != 16'h8000);
  endfunction

endpackage

// File: rtl/mdio_tick_gen.sv
module mdio_tick_gen #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_MAX = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_n;

  assign tick_o = en_i && (cnt_q == CNT_MAX);

  always_comb begin
    cnt_n = cnt_q;
    if (!en_i)       cnt_n = '0;
    else if (tick_o) cnt_n = '0;
    else             cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_n;
  end

  generate
    if (HALF_DIV > 1) begin : g_gap
      // R7
      tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine #(
  parameter int unsigned PRE_LEN = 32,
  parameter int unsigned DW      = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          wr_i,
  input  logic [4:0]    phy_i,
  input  logic [4:0]    reg_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          tick_i,
  input  logic          mdio_i,
  output logic          run_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          mdc_o,
  output logic          mdo_o,
  output logic          mdoe_o
);
  // frame layout: preamble, start(2), op(2), addr(5), reg(5), turnaround(2), data, tail(1)
  localparam int unsigned I_TA = PRE_LEN + 14;
  localparam int unsigned FL   = I_TA + 2 + DW + 1;
  localparam int unsigned IW   = $clog2(FL);

  logic          run_q, run_n;
  logic          ph_q, ph_n;
  logic          wr_q, wr_n;
  logic [IW-1:0] idx_q, idx_n;
  logic [FL-1:0] tx_q, tx_n, oe_q, oe_n;
  logic [DW-1:0] rx_q, rx_n;
  logic          done_q, done_n;
  logic          mdc_q, mdo_q, mdoe_q;
  logic [FL-1:0] frame_tx, frame_oe;
  logic [IW-1:0] last_idx;

  assign frame_tx = {{PRE_LEN{1'b1}}, 2'b01,
                     (wr_i ? 2'b01 : 2'b10),
                     phy_i, reg_i,
                     (wr_i ? 2'b10 : 2'b00),
                     (wr_i ? wdata_i : {DW{1'b0}}),
                     1'b0};
  assign frame_oe = wr_i ? {{(FL-1){1'b1}}, 1'b0}
                         : {{I_TA{1'b1}}, {(FL-I_TA){1'b0}}};
  assign last_idx = wr_q ? IW'(FL - 1) : IW'(FL - 2);

  always_comb begin
    run_n  = run_q;
    ph_n   = ph_q;
    wr_n   = wr_q;
    idx_n  = idx_q;
    tx_n   = tx_q;
    oe_n   = oe_q;
    rx_n   = rx_q;
    done_n = 1'b0;
    if (!run_q) begin
      if (start_i) begin
        run_n = 1'b1;
        ph_n  = 1'b0;
        wr_n  = wr_i;
        idx_n = '0;
        tx_n  = frame_tx;
        oe_n  = frame_oe;
      end
    end else if (tick_i) begin
      if (!ph_q) begin
        ph_n = 1'b1;
      end else begin
        rx_n = {rx_q[DW-2:0], mdio_i};
        ph_n = 1'b0;
        if (idx_q == last_idx) begin
          run_n  = 1'b0;
          done_n = 1'b1;
        end else begin
          idx_n = idx_q + 1'b1;
          tx_n  = {tx_q[FL-2:0], 1'b0};
          oe_n  = {oe_q[FL-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      ph_q   <= 1'b0;
      wr_q   <= 1'b0;
      idx_q  <= '0;
      tx_q   <= '0;
      oe_q   <= '0;
      rx_q   <= '0;
      done_q <= 1'b0;
      mdc_q  <= 1'b0;
      mdo_q  <= 1'b0;
      mdoe_q <= 1'b0;
    end else begin
      run_q  <= run_n;
      ph_q   <= ph_n;
      wr_q   <= wr_n;
      idx_q  <= idx_n;
      tx_q   <= tx_n;
      oe_q   <= oe_n;
      rx_q   <= rx_n;
      done_q <= done_n;
      mdc_q  <= run_n & ph_n;
      mdo_q  <= run_n & oe_n[FL-1] & tx_n[FL-1];
      mdoe_q <= run_n & oe_n[FL-1];
    end
  end

  assign run_o   = run_q;
  assign done_o  = done_q;
  assign rdata_o = rx_q;
  assign mdc_o   = mdc_q;
  assign mdo_o   = mdo_q;
  assign mdoe_o  = mdoe_q;

  // R5
  mdo_low_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mdo_q) |-> !mdc_q);
  // R6
  idle_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (!mdc_q && !mdo_q && !mdoe_q));
  // R12
  frame_end_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_q) |-> done_q);

endmodule

// File: rtl/mdio_phy_sweep.sv
module mdio_phy_sweep import mdio_pkg::*; #(
  parameter int unsigned DW        = 16,
  parameter int unsigned ID_HI_REG = 2,
  parameter int unsigned ID_LO_REG = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              eng_done_i,
  input  logic [DW-1:0]     eng_rdata_i,
  output logic              issue_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [REG_W-1:0]  reg_o,
  output logic              done_o,
  output logic              found_o,
  output logic [ADDR_W-1:0] found_addr_o
);
  typedef enum logic [1:0] {SW_IDLE, SW_ID1, SW_ID2} sw_state_e;
  localparam logic [ADDR_W-1:0] ADDR_MAX = '1;

  sw_state_e         st_q, st_n;
  logic [ADDR_W-1:0] addr_q, addr_n, faddr_q, faddr_n;
  logic [15:0]       id1_q, id1_n;
  logic              issue_q, issue_n, done_q, done_n, found_q, found_n;

  always_comb begin
    st_n    = st_q;
    addr_n  = addr_q;
    id1_n   = id1_q;
    issue_n = 1'b0;
    done_n  = 1'b0;
    found_n = found_q;
    faddr_n = faddr_q;
    case (st_q)
      SW_IDLE: if (start_i) begin
        addr_n  = '0;
        found_n = 1'b0;
        faddr_n = '0;
        st_n    = SW_ID1;
        issue_n = 1'b1;
      end
      SW_ID1: if (eng_done_i) begin
        id1_n   = eng_rdata_i[15:0];
        st_n    = SW_ID2;
        issue_n = 1'b1;
      end
      SW_ID2: if (eng_done_i) begin
        if (id_word_ok(id1_q) && id_word_ok(eng_rdata_i[15:0])) begin
          found_n = 1'b1;
          faddr_n = addr_q;
          done_n  = 1'b1;
          st_n    = SW_IDLE;
        end else if (addr_q == ADDR_MAX) begin
          done_n = 1'b1;
          st_n   = SW_IDLE;
        end else begin
          addr_n  = addr_q + 1'b1;
          st_n    = SW_ID1;
          issue_n = 1'b1;
        end
      end
      default: st_n = SW_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SW_IDLE;
      addr_q  <= '0;
      id1_q   <= '0;
      issue_q <= 1'b0;
      done_q  <= 1'b0;
      found_q <= 1'b0;
      faddr_q <= '0;
    end else begin
      st_q    <= st_n;
      addr_q  <= addr_n;
      id1_q   <= id1_n;
      issue_q <= issue_n;
      done_q  <= done_n;
      found_q <= found_n;
      faddr_q <= faddr_n;
    end
  end

  assign issue_o      = issue_q;
  assign addr_o       = addr_q;
  assign reg_o        = (st_q == SW_ID2) ? REG_W'(ID_LO_REG) : REG_W'(ID_HI_REG);
  assign done_o       = done_q;
  assign found_o      = found_q;
  assign found_addr_o = faddr_q;

  // R8
  addr_ascend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != SW_IDLE) && $past(st_q != SW_IDLE) |-> addr_q >= $past(addr_q));
  // R9
  found_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(found_q) |-> done_q);
  // R10
  miss_last_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !found_q) |-> addr_q == ADDR_MAX);

endmodule

// File: rtl/mdio_scan_master.sv
module mdio_scan_master import mdio_pkg::*; #(
  parameter int unsigned HALF_DIV  = 2,
  parameter int unsigned PRE_LEN   = 32,
  parameter int unsigned DW        = 16,
  parameter int unsigned ID_HI_REG = 2,
  parameter int unsigned ID_LO_REG = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [1:0]    req_op_i,
  input  logic [4:0]    req_phy_i,
  input  logic [4:0]    req_reg_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          found_o,
  output logic [4:0]    found_phy_o,
  output logic          mdc_o,
  output logic          mdio_o,
  output logic          mdio_oe_o,
  input  logic          mdio_i
);
  logic [1:0] rst_sync_q;
  logic       rst_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  logic          busy_q, busy_n, done_q, done_n;
  logic [1:0]    op_q, op_n;
  logic [DW-1:0] rdata_q, rdata_n;
  logic          accept, sweep_mode, host_fin;

  logic          eng_start, eng_wr, eng_run, eng_done, tick;
  logic [4:0]    eng_phy, eng_reg;
  logic [DW-1:0] eng_rdata;
  logic          sw_issue, sw_done, sw_found;
  logic [4:0]    sw_addr, sw_reg, sw_faddr;

  assign accept     = req_valid_i && !busy_q;
  assign sweep_mode = busy_q && op_q[1];
  assign host_fin   = eng_done && busy_q && !op_q[1];

  assign eng_start = (accept && !req_op_i[1]) || sw_issue;
  assign eng_wr    = sweep_mode ? 1'b0    : req_op_i[0];
  assign eng_phy   = sweep_mode ? sw_addr : req_phy_i;
  assign eng_reg   = sweep_mode ? sw_reg  : req_reg_i;

  mdio_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_s),
    .en_i   (eng_run),
    .tick_o (tick)
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN), .DW(DW)) u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_s),
    .start_i (eng_start),
    .wr_i    (eng_wr),
    .phy_i   (eng_phy),
    .reg_i   (eng_reg),
    .wdata_i (req_wdata_i),
    .tick_i  (tick),
    .mdio_i  (mdio_i),
    .run_o   (eng_run),
    .done_o  (eng_done),
    .rdata_o (eng_rdata),
    .mdc_o   (mdc_o),
    .mdo_o   (mdio_o),
    .mdoe_o  (mdio_oe_o)
  );

  mdio_phy_sweep #(.DW(DW), .ID_HI_REG(ID_HI_REG), .ID_LO_REG(ID_LO_REG)) u_sweep (
    .clk_i        (clk_i),
    .rst_ni       (rst_s),
    .start_i      (accept && req_op_i[1]),
    .eng_done_i   (eng_done && sweep_mode),
    .eng_rdata_i  (eng_rdata),
    .issue_o      (sw_issue),
    .addr_o       (sw_addr),
    .reg_o        (sw_reg),
    .done_o       (sw_done),
    .found_o      (sw_found),
    .found_addr_o (sw_faddr)
  );

  always_comb begin
    busy_n  = busy_q;
    op_n    = op_q;
    rdata_n = rdata_q;
    done_n  = 1'b0;
    if (accept) begin
      busy_n = 1'b1;
      op_n   = req_op_i;
    end else if (host_fin || (sw_done && busy_q)) begin
      busy_n = 1'b0;
      done_n = 1'b1;
      if (host_fin && !op_q[0]) rdata_n = eng_rdata;
    end
  end

  always_ff @(posedge clk_i or negedge rst_s) begin
    if (!rst_s) begin
      busy_q  <= 1'b0;
      op_q    <= OP_READ;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      busy_q  <= busy_n;
      op_q    <= op_n;
      rdata_q <= rdata_n;
      done_q  <= done_n;
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign rdata_o     = rdata_q;
  assign found_o     = sw_found;
  assign found_phy_o = sw_faddr;

  // R12
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_s)
    done_q |=> !done_q);
  // R12
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_s)
    done_q |-> !busy_q);
  // R11
  busy_from_req_chk: assert property (@(posedge clk_i) disable iff (!rst_s)
    $rose(busy_q) |-> $past(req_valid_i));
  // R6
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_s)
    !busy_q |-> (!mdc_o && !mdio_oe_o));

endmodule

// File: tb/mdio_scan_master_tb_top.sv
module mdio_scan_master_tb_top;
  localparam int H = 2;

  logic        clk, rst_n;
  logic        req_valid;
  logic [1:0]  req_op;
  logic [4:0]  req_phy, req_reg;
  logic [15:0] req_wdata;
  logic        busy, done, found, mdc, mdo, mdoe, mdin;
  logic [15:0] rdata;
  logic [4:0]  found_phy;

  int checks = 0;
  int fails  = 0;

  mdio_scan_master #(.HALF_DIV(H)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_phy_i(req_phy), .req_reg_i(req_reg), .req_wdata_i(req_wdata),
    .busy_o(busy), .done_o(done), .rdata_o(rdata), .found_o(found),
    .found_phy_o(found_phy), .mdc_o(mdc), .mdio_o(mdo), .mdio_oe_o(mdoe),
    .mdio_i(mdin)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // ---------------- PHY model ----------------
  logic [15:0] mem [32][32];
  logic b_val [0:64];
  logic b_oe  [0:64];
  int   bidx, hi_cnt, lo_cnt, hi_bad, lo_bad, r5_bad, fmt_bad, frames, done_cnt, dbl_done;
  logic prev_mdc, prev_mdo, prev_done, phy_drv, phy_val, cur_rd, last_wr;
  logic [4:0]  cur_a, cur_r, last_a, last_r;
  logic [15:0] last_d;
  logic [4:0]  seq_a [0:127];
  logic [4:0]  seq_r [0:127];

  assign mdin = mdoe ? mdo : (phy_drv ? phy_val : 1'b1);

  task automatic finalize_frame();
    logic bad;
    logic [15:0] d;
    bad = 1'b0;
    for (int i = 0; i < 32; i++) if (!b_val[i] || !b_oe[i]) bad = 1'b1;
    if (b_val[32] || !b_val[33] || !b_oe[32] || !b_oe[33]) bad = 1'b1;
    for (int i = 34; i < 46; i++) if (!b_oe[i]) bad = 1'b1;
    if (cur_rd) begin
      for (int i = 46; i < 64; i++) if (b_oe[i]) bad = 1'b1;
    end else begin
      if (!b_val[46] || b_val[47]) bad = 1'b1;
      for (int i = 46; i < 64; i++) if (!b_oe[i]) bad = 1'b1;
      if (b_oe[64]) bad = 1'b1;
    end
    if (bad) fmt_bad++;
    for (int i = 48; i < 64; i++) d[63-i] = b_val[i];
    if (frames < 128) begin seq_a[frames] = cur_a; seq_r[frames] = cur_r; end
    frames++;
    last_wr = !cur_rd; last_a = cur_a; last_r = cur_r; last_d = d;
    if (!cur_rd) mem[cur_a][cur_r] = d;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      bidx = 0; hi_cnt = 0; lo_cnt = 0; phy_drv = 1'b0; phy_val = 1'b1;
      prev_mdc = 1'b0; prev_mdo = 1'b0; prev_done = 1'b0; cur_rd = 1'b0;
    end else begin
      if (mdo != prev_mdo && mdc && prev_mdc) r5_bad++;
      if (done) done_cnt++;
      if (done && prev_done) dbl_done++;
      if (mdc && !prev_mdc) begin
        if (bidx > 0 && lo_cnt != H) lo_bad++;
        if (bidx <= 64) begin b_val[bidx] = mdo; b_oe[bidx] = mdoe; end
        bidx++;
        if (bidx == 36) cur_rd = b_val[34] & ~b_val[35];
        if (bidx == 46) begin
          cur_a = {b_val[36], b_val[37], b_val[38], b_val[39], b_val[40]};
          cur_r = {b_val[41], b_val[42], b_val[43], b_val[44], b_val[45]};
        end
      end
      if (!mdc && prev_mdc) begin
        int k;
        if (hi_cnt != H) hi_bad++;
        k = bidx - 1;
        if (cur_rd && bidx >= 46 && k >= 47 && k <= 62) begin
          phy_drv = 1'b1; phy_val = mem[cur_a][cur_r][62-k];
        end else phy_drv = 1'b0;
        if ((cur_rd && bidx == 64) || (!cur_rd && bidx == 65)) begin
          finalize_frame();
          bidx = 0;
        end
      end
      if (mdc) hi_cnt = (!prev_mdc) ? 1 : hi_cnt + 1;
      else     lo_cnt = (prev_mdc)  ? 1 : lo_cnt + 1;
      prev_mdc = mdc; prev_mdo = mdo; prev_done = done;
    end
  end

  // ---------------- helpers ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: got %0d cycles expected under 150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int a = 0; a < 32; a++)
      for (int r = 0; r < 32; r++) mem[a][r] = 16'hFFFF;
  endtask

  task automatic send(input logic [1:0] op, input logic [4:0] a, input logic [4:0] r, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_phy = a; req_reg = r; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (!done && n < 40000) begin @(negedge clk); n++; end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(busy == 1'b0, "R12 busy after reset", busy, 0);
    chk(done == 1'b0, "R12 done after reset", done, 0);
    chk({mdc, mdo, mdoe} == 3'b000, "R6 pins after reset", {mdc, mdo, mdoe}, 0);
    chk(found == 1'b0, "R10 found after reset", found, 0);
  endtask

  task automatic t_write();
    int f0, d0;
    f0 = frames; d0 = done_cnt;
    send(2'b01, 5'h0A, 5'h11, 16'hA55A);
    chk(busy == 1'b1, "R12 busy after accept", busy, 1);
    wait_done();
    chk(done == 1'b1, "R12 write done", done, 1);
    chk(!busy, "R12 busy low at done", busy, 0);
    chk(frames == f0 + 1, "R4 one write frame of 65 clocks", frames - f0, 1);
    chk(last_wr, "R2 write opcode", last_wr, 1);
    chk(last_a == 5'h0A, "R2 write addr", last_a, 5'h0A);
    chk(last_r == 5'h11, "R2 write reg", last_r, 5'h11);
    chk(last_d == 16'hA55A, "R4 write data", last_d, 16'hA55A);
    @(negedge clk);
    chk({mdc, mdo, mdoe} == 3'b000, "R6 pins idle after write", {mdc, mdo, mdoe}, 0);
    chk(done == 1'b0 && done_cnt == d0 + 1, "R12 single done pulse", done_cnt - d0, 1);
  endtask

  task automatic t_read(input logic [4:0] a, input logic [4:0] r, input logic [15:0] v);
    int f0;
    mem[a][r] = v; f0 = frames;
    send(2'b00, a, r, 16'h0);
    wait_done();
    chk(rdata == v, "R3 read data", rdata, v);
    chk(frames == f0 + 1 && !last_wr, "R2 read opcode and frame", frames - f0, 1);
    chk(last_a == a && last_r == r, "R2 read addr/reg", {last_a, last_r}, {a, r});
    @(negedge clk);
    chk({mdc, mdo, mdoe} == 3'b000, "R6 pins idle after read", {mdc, mdo, mdoe}, 0);
  endtask

  task automatic t_busy_ignore();
    int f0, d0;
    mem[1][1] = 16'h1234; mem[2][2] = 16'h0000;
    f0 = frames; d0 = done_cnt;
    send(2'b00, 5'd1, 5'd1, 16'h0);
    repeat (30) @(negedge clk);
    send(2'b01, 5'd2, 5'd2, 16'hBEEF);
    wait_done();
    repeat (400) @(negedge clk);
    chk(frames == f0 + 1, "R11 no frame for ignored request", frames - f0, 1);
    chk(mem[2][2] == 16'h0000, "R11 PHY register untouched", mem[2][2], 0);
    chk(done_cnt == d0 + 1, "R11 no extra done", done_cnt - d0, 1);
    chk(rdata == 16'h1234 && !busy, "R11 first request result", rdata, 16'h1234);
  endtask

  task automatic t_sweep(input string tag, input logic exp_found, input logic [4:0] exp_a);
    int f0, nf;
    logic order_ok;
    f0 = frames;
    send(2'b10, 5'h0, 5'h0, 16'h0);
    wait_done();
    nf = exp_found ? 2 * (exp_a + 1) : 64;
    chk(found == exp_found, {tag, " found flag"}, found, exp_found);
    if (exp_found) chk(found_phy == exp_a, {tag, " found address"}, found_phy, exp_a);
    chk(frames - f0 == nf, {tag, " R8 frame count"}, frames - f0, nf);
    order_ok = 1'b1;
    for (int i = 0; i < nf; i++) begin
      if (f0 + i < 128) begin
        if (seq_a[f0+i] != 5'(i / 2)) order_ok = 1'b0;
        if (seq_r[f0+i] != ((i % 2) ? 5'd3 : 5'd2)) order_ok = 1'b0;
      end
    end
    chk(order_ok, {tag, " R8 address/register order"}, order_ok, 1);
    @(negedge clk);
    chk(!busy && !done, {tag, " R12 sweep completion"}, {busy, done}, 0);
  endtask

  initial begin
    req_valid = 1'b0; req_op = 2'b00; req_phy = '0; req_reg = '0; req_wdata = '0;
    hi_bad = 0; lo_bad = 0; r5_bad = 0; fmt_bad = 0; frames = 0; done_cnt = 0; dbl_done = 0;
    last_wr = 1'b0; last_a = '0; last_r = '0; last_d = '0; cur_a = '0; cur_r = '0;
    clear_mem();
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    t_reset();
    t_write();
    t_read(5'd3, 5'd7, 16'hC3A5);
    t_read(5'd31, 5'd31, 16'h8001);
    t_busy_ignore();

    // R9: invalid patterns at 0..3, first valid at 4, another at 9
    clear_mem();
    mem[0][2] = 16'h0000; mem[0][3] = 16'h1234;
    mem[1][2] = 16'h1234; mem[1][3] = 16'h8000;
    mem[2][2] = 16'h8000; mem[2][3] = 16'h1111;
    mem[3][2] = 16'h0022; mem[3][3] = 16'hFFFF;
    mem[4][2] = 16'h0022; mem[4][3] = 16'h1561;
    mem[9][2] = 16'h0282; mem[9][3] = 16'h1C51;
    t_sweep("R9 early hit", 1'b1, 5'd4);

    // R10: nothing valid
    clear_mem();
    mem[6][2] = 16'h0000; mem[6][3] = 16'h0000;
    mem[7][2] = 16'h4444; mem[7][3] = 16'h0000;
    t_sweep("R10 miss", 1'b0, 5'd0);

    // R9: only the last address
    clear_mem();
    mem[31][2] = 16'h7FFF; mem[31][3] = 16'h0001;
    t_sweep("R9 last address", 1'b1, 5'd31);

    chk(fmt_bad == 0, "R1 frame layout errors", fmt_bad, 0);
    chk(r5_bad == 0, "R5 data change while clock high", r5_bad, 0);
    chk(hi_bad == 0, "R7 high phase width", hi_bad, 0);
    chk(lo_bad == 0, "R7 low phase width", lo_bad, 0);
    chk(dbl_done == 0, "R12 done wider than one cycle", dbl_done, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule